// File: doc/BRIEF.md
# Ternary Bitwise Logic Execution Unit

This unit executes a three-input bitwise logic instruction on 64-bit operands. It takes a 32-bit instruction word and decodes it. From the word it drives the three register read addresses combinationally. In the same cycle it accepts the three operand values from the register file. The inputs are the old value of the target register and the values of the two source registers.

For every bit position the three operand bits form a 3-bit index into an 8-bit truth table carried in the instruction. The target register bit is the most significant bit of that index. Any Boolean function of three inputs can therefore be selected. One cycle after a valid instruction is presented, the unit raises a valid strobe with the result. It also raises a target-register write enable when the word decodes as this instruction. When the record flag is set, it additionally raises a condition-field write enable with a 4-bit field that classifies the signed result.

Top module: `ternlog_unit`

## Requirements
- R1: The instruction word fields are, from bit 31 down: opcode [31:26], target register [25:21], first source [20:16], second source [15:11], truth table [10:3], sub-opcode [2:1] and record flag [0]. The word is accepted when the opcode is 5 and the sub-opcode is 0. One cycle after an accepted word with `valid_i` high, `rt_we_o` is 1 and `rt_addr_o` equals the target register field.
- R2: A word with any other opcode or sub-opcode still gives `valid_o` one cycle later, but `rt_we_o` and `cr_we_o` stay 0.
- R3: Result bit i equals truth-table bit number {rt[i], ra[i], rb[i]}, where the target register value is the MSB of the index and the second source is the LSB.
- R4: `cr_we_o` is 1 one cycle after an accepted word whose record flag is 1, and is 0 when the record flag is 0.
- R5: The condition field is laid out as bit 3 = result negative as signed 64-bit, bit 2 = result positive, bit 1 = result zero. Exactly one of these three bits is set whenever `cr_we_o` is 1.
- R6: Bit 0 of the condition field is 0 whenever `cr_we_o` is 1.
- R7: Truth table 0xFF with all-zero operands gives an all-ones result with condition field 4'b1000.
- R8: While `rst_ni` is low, `valid_o`, `rt_we_o` and `cr_we_o` are 0.
- R9: `rt_rd_addr_o`, `ra_rd_addr_o` and `rb_rd_addr_o` equal the three register fields of `insn_i` in the same cycle.
- R10: In the cycle after `valid_i` is low, `valid_o`, `rt_we_o` and `cr_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction and operands present |
| insn_i | input | 32 | Instruction word |
| rt_val_i | input | 64 | Old target register value |
| ra_val_i | input | 64 | First source value |
| rb_val_i | input | 64 | Second source value |
| rt_rd_addr_o | output | 5 | Target register read address |
| ra_rd_addr_o | output | 5 | First source read address |
| rb_rd_addr_o | output | 5 | Second source read address |
| valid_o | output | 1 | Result strobe |
| rt_we_o | output | 1 | Target register write enable |
| rt_addr_o | output | 5 | Target register write address |
| result_o | output | 64 | Result value |
| cr_we_o | output | 1 | Condition field write enable |
| cr_field_o | output | 4 | Condition field value |

## Verification
The case that is hardest to reach is a condition field for a result that is exactly zero or has only its sign bit set. Random truth tables and operands almost never produce either. The stimulus therefore includes directed tables: 0x00 for zero, and 0xFF over zero operands for all ones. It also includes a three-way AND table over operands that share only bit 63, which isolates the sign bit. Between these, back-to-back random words mix accepted and rejected encodings and both record-flag values, so that the scoreboard sees enables change from cycle to cycle.

// File: rtl/ternlog_pkg.sv
package ternlog_pkg;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned TBL_W  = 8;
  localparam int unsigned SUB_W  = 2;
  localparam int unsigned LUT_IN = 3;

  localparam logic [OPC_W-1:0] OPC_TLOG = 6'd5;
  localparam logic [SUB_W-1:0] SUB_TLOG = 2'd0;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [REG_AW-1:0] rt;
    logic [REG_AW-1:0] ra;
    logic [REG_AW-1:0] rb;
    logic [TBL_W-1:0]  tbl;
    logic [SUB_W-1:0]  sub;
    logic              rec;
  } insn_t;

  typedef struct packed {
    logic neg;
    logic pos;
    logic zero;
    logic ovf;
  } cond_t;
endpackage

// File: rtl/ternlog_decode.sv
module ternlog_decode
  import ternlog_pkg::*;
(
  input  logic [31:0]       insn_i,
  output logic              hit_o,
  output logic              rec_o,
  output logic [REG_AW-1:0] rt_o,
  output logic [REG_AW-1:0] ra_o,
  output logic [REG_AW-1:0] rb_o,
  output logic [TBL_W-1:0]  tbl_o
);
  insn_t f;
  assign f     = insn_t'(insn_i);
  assign hit_o = (f.opc == OPC_TLOG) && (f.sub == SUB_TLOG);
  assign rec_o = f.rec;
  assign rt_o  = f.rt;
  assign ra_o  = f.ra;
  assign rb_o  = f.rb;
  assign tbl_o = f.tbl;
endmodule

// File: rtl/ternlog_lut_array.sv
module ternlog_lut_array
  import ternlog_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [TBL_W-1:0] tbl_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [XLEN-1:0]  c_i,
  output logic [XLEN-1:0]  y_o
);
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    logic [LUT_IN-1:0] idx;
    assign idx    = {a_i[i], b_i[i], c_i[i]};  // target bit is MSB of index
    assign y_o[i] = tbl_i[idx];
  end
endmodule

// File: rtl/ternlog_cond_gen.sv
module ternlog_cond_gen
  import ternlog_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] val_i,
  output cond_t           cond_o
);
  logic is_zero;
  assign is_zero     = ~|val_i;
  assign cond_o.neg  = val_i[XLEN-1];
  assign cond_o.zero = is_zero;
  assign cond_o.pos  = ~val_i[XLEN-1] & ~is_zero;
  assign cond_o.ovf  = 1'b0;
endmodule

// File: rtl/ternlog_unit.sv
module ternlog_unit
  import ternlog_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       insn_i,
  input  logic [XLEN-1:0]   rt_val_i,
  input  logic [XLEN-1:0]   ra_val_i,
  input  logic [XLEN-1:0]   rb_val_i,
  output logic [REG_AW-1:0] rt_rd_addr_o,
  output logic [REG_AW-1:0] ra_rd_addr_o,
  output logic [REG_AW-1:0] rb_rd_addr_o,
  output logic              valid_o,
  output logic              rt_we_o,
  output logic [REG_AW-1:0] rt_addr_o,
  output logic [XLEN-1:0]   result_o,
  output logic              cr_we_o,
  output logic [3:0]        cr_field_o
);
  logic             hit, rec;
  logic [TBL_W-1:0] tbl;
  logic [XLEN-1:0]  lut_y;
  cond_t            cond;

  ternlog_decode u_dec (
    .insn_i (insn_i),
    .hit_o  (hit),
    .rec_o  (rec),
    .rt_o   (rt_rd_addr_o),
    .ra_o   (ra_rd_addr_o),
    .rb_o   (rb_rd_addr_o),
    .tbl_o  (tbl)
  );

  ternlog_lut_array #(.XLEN(XLEN)) u_lut (
    .tbl_i (tbl),
    .a_i   (rt_val_i),
    .b_i   (ra_val_i),
    .c_i   (rb_val_i),
    .y_o   (lut_y)
  );

  ternlog_cond_gen #(.XLEN(XLEN)) u_cond (
    .val_i  (lut_y),
    .cond_o (cond)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rt_we_o <= 1'b0;
      cr_we_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      rt_we_o <= valid_i & hit;
      cr_we_o <= valid_i & hit & rec;
    end
  end

  // data path: no reset needed, qualified by enables
  always_ff @(posedge clk_i) begin
    if (valid_i) begin
      rt_addr_o  <= rt_rd_addr_o;
      result_o   <= lut_y;
      cr_field_o <= cond;
    end
  end

  p_we_needs_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_we_o |-> valid_o);
  p_cr_needs_rt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> rt_we_o);
  p_cr_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> ($countones(cr_field_o[3:1]) == 1));
  p_cr_sign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> (cr_field_o[3] == result_o[XLEN-1]));
  p_no_ovf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> !cr_field_o[0]);
  p_valid_follows_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !rt_we_o && !cr_we_o));
endmodule

// File: tb/ternlog_unit_test.sv
module ternlog_unit_test;
  localparam int XLEN = 64;

  typedef struct {
    logic             rt_we;
    logic [4:0]       addr;
    logic [XLEN-1:0]  res;
    logic             cr_we;
    logic [3:0]       cr;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid = 1'b0;
  logic [31:0]     insn = '0;
  logic [XLEN-1:0] rtv = '0, rav = '0, rbv = '0;
  logic [4:0]      rt_ra, ra_ra, rb_ra;
  logic            valid_o, rt_we_o, cr_we_o;
  logic [4:0]      rt_addr_o;
  logic [XLEN-1:0] result_o;
  logic [3:0]      cr_field_o;

  int   n_chk = 0, n_bad = 0;
  bit   done = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  ternlog_unit #(.XLEN(XLEN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn),
    .rt_val_i(rtv), .ra_val_i(rav), .rb_val_i(rbv),
    .rt_rd_addr_o(rt_ra), .ra_rd_addr_o(ra_ra), .rb_rd_addr_o(rb_ra),
    .valid_o(valid_o), .rt_we_o(rt_we_o), .rt_addr_o(rt_addr_o),
    .result_o(result_o), .cr_we_o(cr_we_o), .cr_field_o(cr_field_o)
  );

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] t, a, b,
                                     input logic [7:0] tbl, input logic [1:0] sub, input logic rec);
    return {opc, t, a, b, tbl, sub, rec};
  endfunction

  // R3 model
  function automatic logic [XLEN-1:0] model(input logic [7:0] tbl, input logic [XLEN-1:0] t, a, b);
    logic [XLEN-1:0] y;
    for (int i = 0; i < XLEN; i++) y[i] = tbl[{t[i], a[i], b[i]}];
    return y;
  endfunction

  // R5/R6 model
  function automatic logic [3:0] cond(input logic [XLEN-1:0] y);
    if ($signed(y) < 0) return 4'b1000;
    if (y == '0) return 4'b0010;
    return 4'b0100;
  endfunction

  task automatic drive(input logic [31:0] w, input logic [XLEN-1:0] t, a, b);
    exp_t e;
    logic acc;
    @(negedge clk);
    valid = 1'b1; insn = w; rtv = t; rav = a; rbv = b;
    acc = (w[31:26] == 6'd5) && (w[2:1] == 2'd0);
    e.rt_we = acc;
    e.addr  = w[25:21];
    e.res   = model(w[10:3], t, a, b);
    e.cr_we = acc & w[0];
    e.cr    = cond(e.res);
    sb.push_back(e);
    #1;
    chk("R9 rt addr", {59'd0, rt_ra}, {59'd0, w[25:21]});
    chk("R9 ra addr", {59'd0, ra_ra}, {59'd0, w[20:16]});
    chk("R9 rb addr", {59'd0, rb_ra}, {59'd0, w[15:11]});
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0;
    insn  = $urandom;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid_o) begin
        if (sb.size() == 0) chk("R10 unexpected valid", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk("R1/R2 rt_we", {63'd0, rt_we_o}, {63'd0, e.rt_we});
          chk("R4 cr_we", {63'd0, cr_we_o}, {63'd0, e.cr_we});
          if (e.rt_we) begin
            chk("R1 rt_addr", {59'd0, rt_addr_o}, {59'd0, e.addr});
            chk("R3 result", result_o, e.res);
          end
          if (e.cr_we) chk("R5 R6 cr field", {60'd0, cr_field_o}, {60'd0, e.cr});
        end
      end else begin
        chk("R10 idle enables", {62'd0, rt_we_o, cr_we_o}, 64'd0);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    valid = 1'b1;  // driven during reset: must not leak out (R8)
    repeat (3) @(negedge clk);
    chk("R8 reset outputs", {61'd0, valid_o, rt_we_o, cr_we_o}, 64'd0);
    valid = 1'b0;
    rst_n = 1'b1;
    idle();
    // R7 all ones from zero operands, negative
    drive(mk(6'd5, 5'd3, 5'd4, 5'd5, 8'hFF, 2'd0, 1'b1), '0, '0, '0);
    drive(mk(6'd5, 5'd3, 5'd4, 5'd5, 8'hFF, 2'd0, 1'b0), '0, '0, '0);
    // R3 three-way AND, sign bit shared
    drive(mk(6'd5, 5'd3, 5'd4, 5'd5, 8'h80, 2'd0, 1'b1),
          64'h8000_0000_FFFF_0000, 64'h8000_0000_FF00_FF00, 64'h8000_0000_F0F0_F0F0);
    drive(mk(6'd5, 5'd3, 5'd4, 5'd5, 8'h80, 2'd0, 1'b1),
          64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0002);
    // R5 zero result
    drive(mk(6'd5, 5'd31, 5'd1, 5'd2, 8'h00, 2'd0, 1'b1), '1, '1, '1);
    // R5 positive: select second source only
    drive(mk(6'd5, 5'd7, 5'd8, 5'd9, 8'hAA, 2'd0, 1'b1), '1, '0, 64'h0000_0000_0000_1234);
    // R3 select target only
    drive(mk(6'd5, 5'd0, 5'd1, 5'd2, 8'hF0, 2'd0, 1'b1), 64'h7FFF_0000_0000_0001, '1, '0);
    // R2 rejected encodings
    drive(mk(6'd4, 5'd3, 5'd4, 5'd5, 8'h80, 2'd0, 1'b1), '1, '1, '1);
    drive(mk(6'd5, 5'd3, 5'd4, 5'd5, 8'h80, 2'd1, 1'b1), '1, '1, '1);
    drive(mk(6'd5, 5'd3, 5'd4, 5'd5, 8'h80, 2'd3, 1'b0), '1, '1, '1);
    idle();
    idle();
    for (int k = 0; k < 60; k++) begin
      logic [31:0] w;
      w = $urandom;
      if (k % 4 != 3) begin
        w[31:26] = 6'd5;
        w[2:1]   = 2'd0;
      end
      drive(w, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
      if (k % 7 == 0) idle();
    end
    idle();
    idle();
    idle();
    chk("R10 scoreboard drained", 64'(sb.size()), 64'd0);
    finish_run();
  end
endmodule